// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block drives the per-queue transmit gates of an Ethernet port from a repeating schedule. Software loads a list of gate control words, a base time, a cycle time and an entry count through a simple write port, then commits them. Each word holds a time interval in nanoseconds in its low IVW bits and a gate-open mask for the NQ = 32 - IVW queues above it. The lowest mask bit also acts as the frame-preemption hold control. IVW may be 16, 20 or 24, and the list depth may be 64 to 1024 words.

The block compares a free-running time, given as a seconds word and a nanoseconds word, against the programmed schedule. Starting at the base time, it opens the gates of entry 0. When an entry's interval has run out, it steps to the next entry. After the last counted entry it keeps that entry's gates until the cycle time has elapsed, and then it starts over at entry 0. If the base time is already in the past, the first cycle starts at the next cycle boundary that lies after the current time.

The list storage is double-banked, so a new list can be written while the old one runs. A committed configuration replaces the running one only at the next cycle boundary.

Top module: `gate_sched`

## Requirements
- R1: While a schedule runs, `gate_open` equals bits [31:IVW] of the active list word, and `preempt_hold` equals bit IVW of that word, which is mask bit 0.
- R2: Out of reset, before the first committed schedule has started, and before the aligned start time is reached, `gate_open` is all ones and `preempt_hold` is 0.
- R3: When `sched_en` is sampled low at a clock edge, scheduling stops. After that edge `gate_open` is all ones and `preempt_hold` is 0.
- R4: Register writes use `wr_list`=0, at these addresses: 0 entry count, 1 cycle nanoseconds, 2 cycle seconds, 3 base nanoseconds, 4 base seconds. Any write to address 7 is a commit. A commit is ignored, and the running schedule continues unchanged, when the cycle time is zero, the count is zero, or the count is DEPTH or more.
- R5: A base time at or before the current time T is moved to base + (floor((T - base) / cycle) + 1) * cycle.
- R6: At the aligned start, entry 0 becomes active. Entry k stays active for its interval and then entry k+1 follows. The entry at count-1 stays active until the cycle time elapses.
- R7: When the cycle time elapses, entry 0 becomes active again, even if the intervals of the earlier entries have not all run out.
- R8: A commit made while a schedule runs takes effect at the next cycle boundary. From that boundary until the new aligned start time, all gates are open.
- R9: The time inputs are seconds plus nanoseconds (nanoseconds below 10^9). A schedule runs without a break across a seconds rollover.
- R10: List writes (`wr_list`=1, `wr_addr` = entry index) go to the bank that is not running, and they do not change the outputs of the running schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_en | input | 1 | Enables scheduling; low forces every gate open |
| now_sec | input | 32 | Current time, seconds part |
| now_nsec | input | 32 | Current time, nanoseconds part |
| wr_en | input | 1 | Write strobe |
| wr_list | input | 1 | 1: list word write, 0: register write |
| wr_addr | input | log2(DEPTH) | List index, or register address in bits [2:0] |
| wr_data | input | 32 | Write data |
| gate_open | output | 32-IVW | Per-queue gate-open vector |
| preempt_hold | output | 1 | Preemption hold request |

## Verification
The assertions assume that the time input grows by less than the shortest list interval at each clock, and by less than one cycle time. This guarantees at most one entry change per edge. They also assume that a commit is made away from a cycle boundary, and that the whole list is written to the idle bank before each commit. The stimulus advances time by 20 ns per clock and draws intervals between 40 and 300 ns. It waits until the schedule is in the middle of a cycle before it commits a running change. For a past base time, it places the enable half a cycle away from any boundary, so the aligned start time does not depend on the few clocks the alignment takes.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef logic [63:0] tns_t;

    localparam tns_t NS_PER_S = 64'd1000000000;
    localparam int   CW       = 11;

    localparam logic [2:0] RA_COUNT  = 3'd0;
    localparam logic [2:0] RA_CYC_NS = 3'd1;
    localparam logic [2:0] RA_CYC_S  = 3'd2;
    localparam logic [2:0] RA_BASE_NS = 3'd3;
    localparam logic [2:0] RA_BASE_S = 3'd4;
    localparam logic [2:0] RA_COMMIT = 3'd7;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ALIGN,
        PH_WAIT,
        PH_RUN
    } phase_e;

    typedef struct packed {
        tns_t          base;
        tns_t          cycle;
        logic [CW-1:0] count;
    } sched_cfg_t;

    function automatic tns_t to_ns(input logic [31:0] sec, input logic [31:0] nsec);
        return ({32'd0, sec} * NS_PER_S) + {32'd0, nsec};
    endfunction

endpackage

// File: rtl/gs_list_ram.sv
module gs_list_ram #(
    parameter int DEPTH = 64,
    parameter int IVW   = 24,
    localparam int AW   = $clog2(DEPTH),
    localparam int NQ   = 32 - IVW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_a_addr,
    input  logic [AW-1:0] rd_b_addr,
    output logic [NQ-1:0] rd_a_mask,
    output logic [IVW-1:0] rd_b_intv
);

    logic [31:0] mem [2][DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_bank][wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_a_mask = mem[rd_bank][rd_a_addr][31:IVW];
        rd_b_intv = mem[rd_bank][rd_b_addr][IVW-1:0];
    end

endmodule

// File: rtl/gs_cfg_regs.sv
module gs_cfg_regs
    import gs_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_list,
    input  logic [2:0] wr_reg,
    input  logic [31:0] wr_data,
    output logic       commit_ok,
    output sched_cfg_t new_cfg
);

    logic [31:0] cnt_q, cyc_ns_q, cyc_s_q, base_ns_q, base_s_q;
    logic        reg_wr;
    tns_t        cyc_t;
    logic        cfg_valid;

    assign reg_wr = wr_en && !wr_list;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            cyc_ns_q  <= '0;
            cyc_s_q   <= '0;
            base_ns_q <= '0;
            base_s_q  <= '0;
        end else if (reg_wr) begin
            case (wr_reg)
                RA_COUNT:   cnt_q     <= wr_data;
                RA_CYC_NS:  cyc_ns_q  <= wr_data;
                RA_CYC_S:   cyc_s_q   <= wr_data;
                RA_BASE_NS: base_ns_q <= wr_data;
                RA_BASE_S:  base_s_q  <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        cyc_t         = to_ns(cyc_s_q, cyc_ns_q);
        cfg_valid     = (cyc_t != '0) && (cnt_q != '0) && (cnt_q < 32'(DEPTH));
        commit_ok     = reg_wr && (wr_reg == RA_COMMIT) && cfg_valid;
        new_cfg.base  = to_ns(base_s_q, base_ns_q);
        new_cfg.cycle = cyc_t;
        new_cfg.count = cnt_q[CW-1:0];
    end

endmodule

// File: rtl/gs_sequencer.sv
module gs_sequencer
    import gs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IVW   = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  tns_t           now,
    input  logic           commit_ok,
    input  sched_cfg_t     new_cfg,
    input  logic [IVW-1:0] intv_b,
    output logic           act_bank,
    output logic [AW-1:0]  rd_a_addr,
    output logic [AW-1:0]  rd_b_addr,
    output logic           running
);

    phase_e        phase;
    sched_cfg_t    act, pend;
    logic          pend_v, have_cfg;
    tns_t          t_start, cyc_end, ent_end;
    logic [AW-1:0] idx;
    logic          last_ent, cyc_done, ent_done;
    tns_t          intv;

    always_comb begin
        last_ent  = ({{(CW-AW){1'b0}}, idx} == (act.count - 1'b1));
        cyc_done  = now >= cyc_end;
        ent_done  = now >= ent_end;
        intv      = {{(64-IVW){1'b0}}, intv_b};
        rd_a_addr = idx;
        rd_b_addr = (phase == PH_RUN && !cyc_done) ? idx + 1'b1 : '0;
        running   = (phase == PH_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            act      <= '0;
            pend     <= '0;
            pend_v   <= 1'b0;
            have_cfg <= 1'b0;
            act_bank <= 1'b0;
            t_start  <= '0;
            cyc_end  <= '0;
            ent_end  <= '0;
            idx      <= '0;
        end else if (!en) begin
            phase <= PH_IDLE;
            if (commit_ok) begin
                act      <= new_cfg;
                act_bank <= ~act_bank;
                have_cfg <= 1'b1;
                pend_v   <= 1'b0;
            end else if (pend_v) begin
                act      <= pend;
                act_bank <= ~act_bank;
                pend_v   <= 1'b0;
            end
        end else if (commit_ok && phase != PH_RUN) begin
            act      <= new_cfg;
            act_bank <= ~act_bank;
            have_cfg <= 1'b1;
            pend_v   <= 1'b0;
            phase    <= PH_ALIGN;
            t_start  <= new_cfg.base;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (have_cfg) begin
                        phase   <= PH_ALIGN;
                        t_start <= act.base;
                    end
                end
                PH_ALIGN: begin
                    if (t_start <= now) t_start <= t_start + act.cycle;
                    else                phase   <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (now >= t_start) begin
                        phase   <= PH_RUN;
                        idx     <= '0;
                        cyc_end <= t_start + act.cycle;
                        ent_end <= t_start + intv;
                    end
                end
                PH_RUN: begin
                    if (cyc_done) begin
                        if (pend_v) begin
                            act      <= pend;
                            act_bank <= ~act_bank;
                            pend_v   <= 1'b0;
                            phase    <= PH_ALIGN;
                            t_start  <= pend.base;
                        end else begin
                            idx     <= '0;
                            cyc_end <= cyc_end + act.cycle;
                            ent_end <= cyc_end + intv;
                        end
                    end else if (!last_ent && ent_done) begin
                        idx     <= idx + 1'b1;
                        ent_end <= ent_end + intv;
                    end
                    if (commit_ok) begin
                        pend   <= new_cfg;
                        pend_v <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R4: an adopted configuration is always a legal one
    a_r4_active_cfg_legal: assert property (@(posedge clk) disable iff (rst)
        have_cfg |-> (act.cycle != '0 && act.count != '0 && act.count < CW'(DEPTH)));

    // R6: the entry index never passes the last counted entry
    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        running |-> ({{(CW-AW){1'b0}}, idx} < act.count));

    // R6: inside a cycle the index moves by at most one entry per clock
    a_r6_idx_single_step: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && idx >= $past(idx)) |-> (idx - $past(idx) <= 1));

    // R7: any backward move of the index lands on entry 0
    a_r7_wrap_to_first: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && idx < $past(idx)) |-> (idx == '0));

    // R5: waiting only starts once the aligned start lies ahead of the time
    a_r5_start_ahead: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && $past(phase) == PH_ALIGN) |-> ($past(t_start) > $past(now)));

    // R8: the active configuration only changes at a cycle boundary while running
    a_r8_swap_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (en && running && !cyc_done) |=> $stable(act));

endmodule

// File: rtl/gate_sched.sv
module gate_sched
    import gs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IVW   = 24,
    localparam int AW   = $clog2(DEPTH),
    localparam int NQ   = 32 - IVW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sched_en,
    input  logic [31:0]   now_sec,
    input  logic [31:0]   now_nsec,
    input  logic          wr_en,
    input  logic          wr_list,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    output logic [NQ-1:0] gate_open,
    output logic          preempt_hold
);

    tns_t           now_t;
    logic           commit_ok;
    sched_cfg_t     new_cfg;
    logic           act_bank, running;
    logic [AW-1:0]  rd_a_addr, rd_b_addr;
    logic [NQ-1:0]  rd_a_mask;
    logic [IVW-1:0] rd_b_intv;

    assign now_t = to_ns(now_sec, now_nsec);

    gs_cfg_regs #(.DEPTH(DEPTH)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_list   (wr_list),
        .wr_reg    (wr_addr[2:0]),
        .wr_data   (wr_data),
        .commit_ok (commit_ok),
        .new_cfg   (new_cfg)
    );

    gs_list_ram #(.DEPTH(DEPTH), .IVW(IVW)) u_ram (
        .clk       (clk),
        .wr_en     (wr_en && wr_list),
        .wr_bank   (~act_bank),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_bank   (act_bank),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .rd_a_mask (rd_a_mask),
        .rd_b_intv (rd_b_intv)
    );

    gs_sequencer #(.DEPTH(DEPTH), .IVW(IVW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (sched_en),
        .now       (now_t),
        .commit_ok (commit_ok),
        .new_cfg   (new_cfg),
        .intv_b    (rd_b_intv),
        .act_bank  (act_bank),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .running   (running)
    );

    always_comb begin
        gate_open    = running ? rd_a_mask : '1;
        preempt_hold = running & rd_a_mask[0];
    end

    // R3: a low enable opens every gate and drops the hold on the next cycle
    a_r3_off_opens_all: assert property (@(posedge clk) disable iff (rst)
        !sched_en |=> (gate_open == '1 && !preempt_hold));

    // R1: the hold output follows the lowest gate bit of the running entry
    a_r1_hold_is_gate0: assert property (@(posedge clk) disable iff (rst)
        preempt_hold |-> gate_open[0]);

endmodule

// File: tb/gate_sched_bench.sv
module gate_sched_bench;

    localparam int DEPTH = 64;
    localparam int IVW   = 24;
    localparam int NQ    = 32 - IVW;
    localparam int AW    = $clog2(DEPTH);
    localparam int TICK  = 20;
    localparam int MAXE  = 8;
    localparam longint unsigned NSPS = 64'd1000000000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sched_en = 1'b0;
    logic [31:0]   now_sec = '0;
    logic [31:0]   now_nsec = '0;
    logic          wr_en = 1'b0;
    logic          wr_list = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NQ-1:0] gate_open;
    logic          preempt_hold;

    always #10 clk = ~clk;

    gate_sched #(.DEPTH(DEPTH), .IVW(IVW)) u_gate_sched (
        .clk(clk), .rst(rst), .sched_en(sched_en),
        .now_sec(now_sec), .now_nsec(now_nsec),
        .wr_en(wr_en), .wr_list(wr_list), .wr_addr(wr_addr), .wr_data(wr_data),
        .gate_open(gate_open), .preempt_hold(preempt_hold)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string req = "R2";
    longint unsigned now_t, edge_t;

    // reference schedule
    bit              mdl_en = 0;
    longint unsigned m_start, m_cyc;
    int              m_cnt;
    longint unsigned m_int [MAXE];
    logic [NQ-1:0]   m_msk [MAXE];
    // staged schedule
    bit              sw_pend = 0;
    longint unsigned sw_time, n_start, n_cyc;
    int              n_cnt;
    longint unsigned n_int [MAXE];
    logic [NQ-1:0]   n_msk [MAXE];

    function automatic logic [NQ:0] mdl_eval(longint unsigned t);
        longint unsigned off, acc;
        int k;
        if (!mdl_en || t < m_start) return {1'b0, {NQ{1'b1}}};
        off = (t - m_start) % m_cyc;
        acc = 0;
        k = 0;
        while (k < m_cnt - 1 && off >= acc + m_int[k]) begin
            acc += m_int[k];
            k++;
        end
        return {m_msk[k][0], m_msk[k]};
    endfunction

    function automatic longint unsigned align(longint unsigned base, longint unsigned cyc,
                                              longint unsigned t);
        if (base > t) return base;
        return base + ((t - base) / cyc + 1) * cyc;
    endfunction

    task automatic drive_time();
        now_sec  = 32'(now_t / NSPS);
        now_nsec = 32'(now_t % NSPS);
    endtask

    task automatic adopt_staged();
        m_start = n_start;
        m_cyc   = n_cyc;
        m_cnt   = n_cnt;
        for (int k = 0; k < MAXE; k++) begin
            m_int[k] = n_int[k];
            m_msk[k] = n_msk[k];
        end
    endtask

    task automatic tick();
        logic [NQ:0] exp;
        @(posedge clk);
        edge_t = now_t;
        @(negedge clk);
        if (sw_pend && edge_t >= sw_time) begin
            adopt_staged();
            sw_pend = 0;
        end
        exp = mdl_eval(edge_t);
        checks++;
        if ({preempt_hold, gate_open} !== exp) begin
            errors++;
            $display("FAIL %s t=%0d: gates=%h hold=%b, expected gates=%h hold=%b",
                     req, edge_t, gate_open, preempt_hold, exp[NQ-1:0], exp[NQ]);
        end
        now_t += TICK;
        drive_time();
    endtask

    task automatic wr(bit lst, int addr, logic [31:0] d);
        wr_en = 1'b1; wr_list = lst; wr_addr = AW'(addr); wr_data = d;
        tick();
        wr_en = 1'b0; wr_list = 1'b0;
    endtask

    task automatic fill_rand(int cnt, int slack, output longint unsigned sum);
        sum = 0;
        n_cnt = cnt;
        for (int k = 0; k < MAXE; k++) begin
            n_int[k] = 40 + ($urandom % 260);
            n_msk[k] = NQ'($urandom);
            if (k < cnt) sum += n_int[k];
        end
        n_msk[0][0] = 1'b1;
        n_msk[1][0] = 1'b0;
        n_cyc = longint'(sum) + slack;
    endtask

    task automatic load_shadow(longint unsigned base);
        for (int k = 0; k < n_cnt; k++)
            wr(1'b1, k, {n_msk[k], n_int[k][IVW-1:0]});
        wr(1'b0, 0, 32'(n_cnt));
        wr(1'b0, 1, 32'(n_cyc % NSPS));
        wr(1'b0, 2, 32'(n_cyc / NSPS));
        wr(1'b0, 3, 32'(base % NSPS));
        wr(1'b0, 4, 32'(base / NSPS));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        longint unsigned sum, base, tc;
        void'($urandom(32'd20240611));
        now_t = 64'd1999990000;
        drive_time();

        req = "R2 reset";
        repeat (4) tick();
        rst = 1'b0;
        repeat (4) tick();

        // first schedule: future base, slack after last entry
        req = "R2 idle";
        fill_rand(5, 120, sum);
        base = now_t + 400;
        load_shadow(base);
        n_start = base;
        wr(1'b0, 7, 32'd0);
        adopt_staged();
        sched_en = 1'b1;
        mdl_en   = 1'b1;
        req = "R1/R6/R9 run across rollover";
        repeat (700) tick();

        // staged change while running
        req = "R10 shadow writes";
        fill_rand(6, -150, sum);
        base = now_t + 3 * m_cyc + 200;
        load_shadow(base);
        while (!(((now_t - m_start) % m_cyc) >= m_cyc / 3 &&
                 ((now_t - m_start) % m_cyc) <= m_cyc / 2))
            tick();
        tc = now_t;
        n_start = base;
        sw_time = m_start + ((tc - m_start) / m_cyc + 1) * m_cyc;
        sw_pend = 1;
        wr(1'b0, 7, 32'd0);
        req = "R8 switch at boundary";
        repeat (40 + int'(4 * m_cyc / TICK)) tick();
        req = "R7 truncated cycle";
        repeat (int'(5 * m_cyc / TICK)) tick();

        // illegal commits leave the schedule untouched
        req = "R4 zero cycle";
        wr(1'b0, 1, 32'd0);
        wr(1'b0, 2, 32'd0);
        wr(1'b0, 7, 32'd0);
        repeat (60) tick();
        req = "R4 count at depth";
        wr(1'b0, 1, 32'd500);
        wr(1'b0, 0, 32'(DEPTH));
        wr(1'b0, 7, 32'd0);
        repeat (60) tick();
        req = "R4 zero count";
        wr(1'b0, 0, 32'd0);
        wr(1'b0, 7, 32'd0);
        repeat (60) tick();

        // disable
        req = "R3 disabled";
        sched_en = 1'b0;
        mdl_en   = 1'b0;
        repeat (30) tick();

        // base time in the past
        req = "R5 past base";
        fill_rand(3, 80, sum);
        base = now_t + 9 * TICK - 2 * n_cyc - n_cyc / 2;
        load_shadow(base);
        wr(1'b0, 7, 32'd0);
        n_start = align(base, n_cyc, now_t);
        adopt_staged();
        sched_en = 1'b1;
        mdl_en   = 1'b1;
        repeat (int'(6 * m_cyc / TICK)) tick();

        done = 1;
        finish_run();
    end

endmodule